// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table that sits in ordinary memory. The virtual address splits into three fields: the top ten bits select an entry in the outer table, the next ten bits select an entry in an inner table, and the low twelve bits pass through unchanged as the offset inside a 4 KB page. The outer table always has 1024 entries, and each of them covers a 4 MB region. An inner table is needed only for regions that are in use. A context register holds the byte address of the active outer table, so loading it switches the address space.

Each request carries the virtual address, a write flag and a user-mode flag. The walker reads the outer entry through a single-beat read port and waits as long as the memory needs. It then reads the leaf entry. At each level it checks the entry for presence, write permission and user access. The walk ends in one of two ways. The first is a physical address, built from the leaf frame number and the offset. The second is a fault with a three-bit cause code, in which case the virtual address is captured in a fault-address register. After a clean walk the walker sets the accessed flag in the leaf entry, and also the dirty flag for a write. It writes the entry back only when one of those flags actually changes.

Top module: `ptw_walker`

## Requirements
- R1: While reset is high and after it, `busy`, `rsp_valid`, `mem_rd_req` and `mem_wr_en` are low and `fault_addr` is zero.
- R2: A request is taken when `req_valid` is high and `busy` is low. `busy` then stays high until the cycle after the single `rsp_valid` pulse. A `req_valid` raised while `busy` is high is ignored, and no extra response follows.
- R3: The first read goes to `base + vaddr[31:22]*4`. `base` is the value last written through `base_we`/`base_wdata` before the request was taken.
- R4: The second read goes to `{outer_entry[31:12], 12'h000} + vaddr[21:12]*4`.
- R5: `mem_rd_req` and `mem_rd_addr` hold steady until `mem_rd_valid` arrives, however many cycles that takes. A wait of zero cycles also works.
- R6: A walk with no fault answers `rsp_fault=0` and `rsp_paddr = {leaf[31:12], vaddr[11:0]}`.
- R7: An entry at either level with bit 0 (present) clear ends the walk in a fault with `rsp_err[0]=0`. No later read or write follows it.
- R8: A write request that meets an entry with bit 1 (writable) clear at either level ends in a fault with `rsp_err[0]=1`.
- R9: A user request (`req_user=1`) that meets an entry with bit 2 (user-accessible) clear at either level ends in a fault with `rsp_err[0]=1`.
- R10: On every fault, `rsp_err[1]` equals the request's write flag and `rsp_err[2]` equals its user flag.
- R11: `fault_addr` takes the virtual address of a faulting request. It does not change on any other request.
- R12: After a clean walk the leaf entry is written back to the leaf address with bit 5 (accessed) set, and with bit 6 (dirty) also set on a write. The write happens only if this changes the entry.
- R13: A faulting walk performs no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load the outer-table base register |
| base_wdata | input | 32 | Byte address of the new outer table |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| busy | output | 1 | A walk is in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Result is a fault |
| rsp_err | output | 3 | Fault cause: bit0 protection, bit1 write, bit2 user |
| rsp_paddr | output | 32 | Translated physical address (zero on fault) |
| fault_addr | output | 32 | Virtual address of the most recent fault |
| mem_rd_req | output | 1 | Entry read request, held until served |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data is valid this cycle |
| mem_rd_data | input | 32 | Entry returned by memory |
| mem_wr_en | output | 1 | One-cycle entry write-back strobe |
| mem_wr_addr | output | 32 | Byte address of the written entry |
| mem_wr_data | output | 32 | Updated entry value |

## Verification
Some properties are checked on every cycle. The handshake must be well formed. A pending read must hold its address. A clean result must carry the request's page offset. Each fault must report the captured address and the request's write and user flags. The fault-address register may change only with a fault response. Every write-back must carry the accessed flag and must lead straight to a clean response. Other behaviour shows only in the bench scenarios, where a reference walk over the bench's memory sets the expected values. These cover the exact entry addresses at both levels, and which level and which check raised the fault. They also cover whether a write-back is skipped when the flags are already set, and the effect of switching the base register to a different table.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int PTE_W     = 32;
    localparam int IDX_W     = 10;
    localparam int OFF_W     = 12;
    localparam int FRAME_W   = PA_W - OFF_W;
    localparam int ENT_SHIFT = 2;
    localparam int ERR_W     = 3;

    localparam int FLAG_PRESENT = 0;
    localparam int FLAG_WRITE   = 1;
    localparam int FLAG_USER    = 2;
    localparam int FLAG_ACC     = 5;
    localparam int FLAG_DIRTY   = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OUTER,
        ST_INNER,
        ST_WRITE,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic [VA_W-1:0] va;
        logic            is_wr;
        logic            is_usr;
    } walk_req_t;

    typedef struct packed {
        logic present;
        logic writable;
        logic user_ok;
    } ent_flags_t;

    typedef struct packed {
        logic             fault;
        logic [ERR_W-1:0] err;
    } chk_res_t;

    function automatic logic [IDX_W-1:0] hi_index(logic [VA_W-1:0] va);
        return va[VA_W-1 -: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] lo_index(logic [VA_W-1:0] va);
        return va[OFF_W +: IDX_W];
    endfunction

    function automatic logic [ERR_W-1:0] cause(logic prot, logic wr, logic usr);
        return {usr, wr, prot};
    endfunction
endpackage

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
(
    input  ent_flags_t flags,
    input  logic       is_wr,
    input  logic       is_usr,
    output chk_res_t   res
);
    always_comb begin
        res.fault = 1'b0;
        res.err   = cause(1'b0, is_wr, is_usr);
        if (!flags.present) begin
            res.fault = 1'b1;
        end else if ((is_wr && !flags.writable) || (is_usr && !flags.user_ok)) begin
            res.fault = 1'b1;
            res.err   = cause(1'b1, is_wr, is_usr);
        end
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [PA_W-1:0]    base,
    input  logic [IDX_W-1:0]   hi_idx,
    input  logic [IDX_W-1:0]   lo_idx,
    input  logic [FRAME_W-1:0] tbl_frame,
    output logic [PA_W-1:0]    outer_addr,
    output logic [PA_W-1:0]    inner_addr
);
    logic [PA_W-1:0] hi_ofs;
    logic [PA_W-1:0] lo_ofs;

    assign hi_ofs     = PA_W'(hi_idx) << ENT_SHIFT;
    assign lo_ofs     = PA_W'(lo_idx) << ENT_SHIFT;
    assign outer_addr = base + hi_ofs;
    assign inner_addr = {tbl_frame, {OFF_W{1'b0}}} + lo_ofs;
endmodule

// File: rtl/ptw_leaf_update.sv
module ptw_leaf_update
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] ent,
    input  logic             is_wr,
    output logic [PTE_W-1:0] new_ent,
    output logic             need_wr
);
    always_comb begin
        new_ent           = ent;
        new_ent[FLAG_ACC] = 1'b1;
        if (is_wr) begin
            new_ent[FLAG_DIRTY] = 1'b1;
        end
        need_wr = (new_ent != ent);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             base_we,
    input  logic [PA_W-1:0]  base_wdata,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    output logic             busy,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [ERR_W-1:0] rsp_err,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [VA_W-1:0]  fault_addr,
    output logic             mem_rd_req,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [PTE_W-1:0] mem_rd_data,
    output logic             mem_wr_en,
    output logic [PA_W-1:0]  mem_wr_addr,
    output logic [PTE_W-1:0] mem_wr_data
);
    walk_st_e          state;
    walk_req_t         cur;
    logic [PA_W-1:0]   base_q;
    logic [PA_W-1:0]   rd_addr_q;
    logic [PTE_W-1:0]  wb_ent_q;
    logic [PA_W-1:0]   paddr_q;
    logic              fault_q;
    logic [ERR_W-1:0]  err_q;
    logic [VA_W-1:0]   fault_addr_q;

    logic [IDX_W-1:0]  gen_hi;
    logic [IDX_W-1:0]  gen_lo;
    logic [PA_W-1:0]   outer_addr;
    logic [PA_W-1:0]   inner_addr;
    ent_flags_t        rd_flags;
    chk_res_t          chk;
    logic [PTE_W-1:0]  upd_ent;
    logic              upd_need;

    assign gen_hi   = (state == ST_IDLE) ? hi_index(req_vaddr) : hi_index(cur.va);
    assign gen_lo   = lo_index(cur.va);
    assign rd_flags = '{present:  mem_rd_data[FLAG_PRESENT],
                        writable: mem_rd_data[FLAG_WRITE],
                        user_ok:  mem_rd_data[FLAG_USER]};

    ptw_addr_gen u_addr (
        .base       (base_q),
        .hi_idx     (gen_hi),
        .lo_idx     (gen_lo),
        .tbl_frame  (mem_rd_data[PTE_W-1 -: FRAME_W]),
        .outer_addr (outer_addr),
        .inner_addr (inner_addr)
    );

    ptw_entry_check u_check (
        .flags  (rd_flags),
        .is_wr  (cur.is_wr),
        .is_usr (cur.is_usr),
        .res    (chk)
    );

    ptw_leaf_update u_upd (
        .ent     (mem_rd_data),
        .is_wr   (cur.is_wr),
        .new_ent (upd_ent),
        .need_wr (upd_need)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            cur          <= '0;
            base_q       <= '0;
            rd_addr_q    <= '0;
            wb_ent_q     <= '0;
            paddr_q      <= '0;
            fault_q      <= 1'b0;
            err_q        <= '0;
            fault_addr_q <= '0;
        end else begin
            if (base_we) begin
                base_q <= base_wdata;
            end
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur       <= '{va: req_vaddr, is_wr: req_write, is_usr: req_user};
                        rd_addr_q <= outer_addr;
                        fault_q   <= 1'b0;
                        err_q     <= '0;
                        state     <= ST_OUTER;
                    end
                end
                ST_OUTER: begin
                    if (mem_rd_valid) begin
                        if (chk.fault) begin
                            fault_q      <= 1'b1;
                            err_q        <= chk.err;
                            fault_addr_q <= cur.va;
                            state        <= ST_DONE;
                        end else begin
                            rd_addr_q <= inner_addr;
                            state     <= ST_INNER;
                        end
                    end
                end
                ST_INNER: begin
                    if (mem_rd_valid) begin
                        if (chk.fault) begin
                            fault_q      <= 1'b1;
                            err_q        <= chk.err;
                            fault_addr_q <= cur.va;
                            state        <= ST_DONE;
                        end else begin
                            paddr_q  <= {mem_rd_data[PTE_W-1 -: FRAME_W], cur.va[OFF_W-1:0]};
                            wb_ent_q <= upd_ent;
                            state    <= upd_need ? ST_WRITE : ST_DONE;
                        end
                    end
                end
                ST_WRITE: state <= ST_DONE;
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign mem_rd_req  = (state == ST_OUTER) || (state == ST_INNER);
    assign mem_rd_addr = rd_addr_q;
    assign mem_wr_en   = (state == ST_WRITE);
    assign mem_wr_addr = rd_addr_q;
    assign mem_wr_data = wb_ent_q;
    assign rsp_valid   = (state == ST_DONE);
    assign rsp_fault   = fault_q;
    assign rsp_err     = err_q;
    assign rsp_paddr   = fault_q ? '0 : paddr_q;
    assign fault_addr  = fault_addr_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             req_write,
    input logic             req_user,
    input logic             busy,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [1:0]       err_hi,
    input logic [OFF_W-1:0] rsp_off,
    input logic [VA_W-1:0]  fault_addr,
    input logic             mem_rd_req,
    input logic [PA_W-1:0]  mem_rd_addr,
    input logic             mem_rd_valid,
    input logic             mem_wr_en,
    input logic             wr_acc_bit
);
    logic [VA_W-1:0] cap_va;
    logic            cap_wr;
    logic            cap_us;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_va <= '0;
            cap_wr <= 1'b0;
            cap_us <= 1'b0;
        end else if (req_valid && !busy) begin
            cap_va <= req_vaddr;
            cap_wr <= req_write;
            cap_us <= req_user;
        end
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);
    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !busy);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd_req && !mem_wr_en && !rsp_valid));
    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
    // R6
    page_off_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_off == cap_va[OFF_W-1:0]));
    // R10
    err_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (err_hi == {cap_us, cap_wr}));
    // R11
    fault_va_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (fault_addr == cap_va));
    // R11
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fault_addr) |-> (rsp_valid && rsp_fault));
    // R12
    wb_acc_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> wr_acc_bit);
    // R13
    wb_clean_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> (rsp_valid && !rsp_fault));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .req_write    (req_write),
    .req_user     (req_user),
    .busy         (busy),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .err_hi       (rsp_err[2:1]),
    .rsp_off      (rsp_paddr[11:0]),
    .fault_addr   (fault_addr),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_wr_en    (mem_wr_en),
    .wr_acc_bit   (mem_wr_data[5])
);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        busy, rsp_valid, rsp_fault;
    logic [2:0]  rsp_err;
    logic [31:0] rsp_paddr, fault_addr;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_en;
    logic [31:0] mem_wr_addr, mem_wr_data;

    always #5 clk = ~clk;

    ptw_walker u0 (
        .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .req_user(req_user), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_err(rsp_err), .rsp_paddr(rsp_paddr),
        .fault_addr(fault_addr), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    typedef struct {
        string       tag;
        logic [31:0] va;
        logic        wr;
        logic        us;
        logic        fault;
        logic [2:0]  err;
        logic [31:0] paddr;
        logic [31:0] faddr;
        int          nrd;
        logic [31:0] ra0;
        logic [31:0] ra1;
        logic        wb;
        logic [31:0] wd;
    } exp_t;

    exp_t        exp_arr [0:63];
    int          n_push = 0;
    int          n_pop = 0;
    int          lat = 0;
    logic [31:0] cur_base = '0;
    logic [31:0] last_fault = '0;
    bit          done_flag = 1'b0;

    logic [31:0] mem [logic [31:0]];
    int          n_chk = 0;
    int          n_err = 0;
    int          wcnt = 0;
    int          rst_cyc = 0;
    int          cyc = 0;
    int          rd_n = 0;
    logic [31:0] rd_log [0:3];
    int          wr_n = 0;
    logic [31:0] wr_a = '0;
    logic [31:0] wr_d = '0;

    function automatic logic [31:0] mrd(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic load_tables();
        // context A at 0x10000
        mem[32'h0001_0004] = 32'h0002_0007;
        mem[32'h0001_0008] = 32'h0003_0005;
        mem[32'h0001_000C] = 32'h0000_0000;
        mem[32'h0002_0008] = 32'h0ABC_D007;
        mem[32'h0002_0014] = 32'h0000_0000;
        mem[32'h0002_0018] = 32'h0011_1005;
        mem[32'h0002_001C] = 32'h0022_2003;
        mem[32'h0003_0000] = 32'h0033_3007;
        // context B at 0x50000
        mem[32'h0005_0004] = 32'h0006_0007;
        mem[32'h0006_0008] = 32'h0077_7007;
    endtask

    // Reference walk computed from the requirements
    function automatic exp_t model(string tag, logic [31:0] va, logic wr, logic us);
        exp_t e;
        logic [31:0] ent;
        logic        bad;
        e = '{tag: tag, va: va, wr: wr, us: us, fault: 1'b0, err: 3'b0, paddr: '0,
              faddr: last_fault, nrd: 1, ra0: '0, ra1: '0, wb: 1'b0, wd: '0};
        e.ra0 = cur_base + {20'h0, va[31:22], 2'b00};
        ent   = mrd(e.ra0);
        bad   = 1'b0;
        for (int lvl = 0; lvl < 2; lvl++) begin
            if (!bad) begin
                if (lvl == 1) begin
                    e.nrd = 2;
                    e.ra1 = {ent[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
                    ent   = mrd(e.ra1);
                end
                if (!ent[0]) begin
                    bad = 1'b1; e.err = {us, wr, 1'b0};
                end else if ((wr && !ent[1]) || (us && !ent[2])) begin
                    bad = 1'b1; e.err = {us, wr, 1'b1};
                end
            end
        end
        if (bad) begin
            e.fault = 1'b1;
            e.faddr = va;
        end else begin
            logic [31:0] nd;
            e.paddr = {ent[31:12], va[11:0]};
            nd = ent | 32'h20 | (wr ? 32'h40 : 32'h0);
            e.wb = (nd != ent);
            e.wd = nd;
        end
        return e;
    endfunction

    // Memory model, monitor and scoreboard: the only writer of counters and memory
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            load_tables();
            mem_rd_valid = 1'b0;
            wcnt = 0; rd_n = 0; wr_n = 0;
            rst_cyc++;
            if (rst_cyc == 3) begin
                check(!busy && !rsp_valid && !mem_rd_req && !mem_wr_en, "R1",
                      "idle outputs in reset", {28'h0, busy, rsp_valid, mem_rd_req, mem_wr_en}, 32'h0);
                check(fault_addr == 32'h0, "R1", "fault_addr in reset", fault_addr, 32'h0);
            end
        end else begin
            if (rst_cyc > 0 && cyc == rst_cyc + 2) begin
                check(!busy && !rsp_valid && !mem_rd_req && !mem_wr_en, "R1",
                      "idle outputs after reset", {28'h0, busy, rsp_valid, mem_rd_req, mem_wr_en}, 32'h0);
            end
            if (mem_wr_en) begin
                mem[mem_wr_addr] = mem_wr_data;
                wr_n++; wr_a = mem_wr_addr; wr_d = mem_wr_data;
            end
            if (mem_rd_valid) begin
                mem_rd_valid = 1'b0;
            end else if (mem_rd_req) begin
                if (wcnt >= lat) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = mrd(mem_rd_addr);
                    if (rd_n < 4) rd_log[rd_n] = mem_rd_addr;
                    rd_n++;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
            if (rsp_valid) begin
                if (n_pop >= n_push) begin
                    check(1'b0, "R2", "unexpected response", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_arr[n_pop];
                    n_pop++;
                    check(rsp_fault == e.fault, e.tag, "fault flag", {31'h0, rsp_fault}, {31'h0, e.fault});
                    if (e.fault) begin
                        check(rsp_err == e.err, e.tag, "error code", {29'h0, rsp_err}, {29'h0, e.err});
                        check(rsp_err[2:1] == {e.us, e.wr}, "R10", "error access bits",
                              {30'h0, rsp_err[2:1]}, {30'h0, e.us, e.wr});
                        check(wr_n == 0, "R13", "no write-back on fault", wr_n, 0);
                    end else begin
                        check(rsp_paddr == e.paddr, "R6", "physical address", rsp_paddr, e.paddr);
                        check(wr_n == (e.wb ? 1 : 0), "R12", "write-back count", wr_n, e.wb ? 1 : 0);
                        if (e.wb && wr_n == 1) begin
                            check(wr_a == e.ra1, "R12", "write-back address", wr_a, e.ra1);
                            check(wr_d == e.wd, "R12", "write-back data", wr_d, e.wd);
                        end
                    end
                    check(fault_addr == e.faddr, "R11", "fault address", fault_addr, e.faddr);
                    check(rd_n == e.nrd, e.fault ? "R7" : "R4", "read count", rd_n, e.nrd);
                    if (rd_n >= 1) check(rd_log[0] == e.ra0, "R3", "outer read address", rd_log[0], e.ra0);
                    if (rd_n >= 2 && e.nrd == 2)
                        check(rd_log[1] == e.ra1, "R4", "inner read address", rd_log[1], e.ra1);
                end
                rd_n = 0; wr_n = 0;
            end
            if (done_flag) begin
                check(n_pop == n_push, "R2", "responses vs requests", n_pop, n_push);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
            if (cyc > 100000) begin
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic set_base(logic [31:0] b);
        wait_idle();
        base_we = 1'b1; base_wdata = b; cur_base = b;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic issue(string tag, logic [31:0] va, logic wr, logic us, int l, bit noise);
        exp_t e;
        wait_idle();
        lat = l;
        e = model(tag, va, wr, us);
        if (e.fault) last_fault = va;
        exp_arr[n_push] = e;
        n_push++;
        req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (noise) begin
            // R2: strobes while busy must be ignored
            req_vaddr = 32'hFFC0_0000; req_write = 1'b1; req_user = 1'b1; req_valid = 1'b1;
            repeat (2) @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        set_base(32'h0001_0000);
        issue("R6",  32'h0040_2345, 1'b0, 1'b1, 0, 1'b0); // first read: accessed set
        issue("R12", 32'h0040_2345, 1'b0, 1'b1, 1, 1'b0); // flags already set: no write
        issue("R12", 32'h0040_2345, 1'b1, 1'b1, 3, 1'b1); // write: dirty set, noise while busy
        issue("R12", 32'h0040_2345, 1'b1, 1'b0, 0, 1'b0); // dirty already set: no write
        issue("R7",  32'h00C0_0010, 1'b1, 1'b1, 2, 1'b0); // outer not present
        issue("R7",  32'h0040_5ABC, 1'b0, 1'b0, 5, 1'b1); // inner not present
        issue("R8",  32'h0040_6008, 1'b1, 1'b1, 1, 1'b0); // read-only leaf
        issue("R6",  32'h0040_6008, 1'b0, 1'b1, 4, 1'b0); // same leaf readable
        issue("R9",  32'h0040_7000, 1'b0, 1'b1, 0, 1'b0); // supervisor leaf from user
        issue("R6",  32'h0040_7000, 1'b1, 1'b0, 2, 1'b0); // supervisor write allowed
        issue("R8",  32'h0080_0000, 1'b1, 1'b1, 3, 1'b0); // outer read-only
        issue("R5",  32'h0080_0FFC, 1'b0, 1'b1, 7, 1'b0); // long wait, clean
        set_base(32'h0005_0000);
        issue("R3",  32'h0040_2345, 1'b0, 1'b1, 1, 1'b0); // other context
        issue("R9",  32'h0040_2000, 1'b0, 1'b0, 0, 1'b0); // inner idx 2 of B, supervisor ok
        wait_idle();
        repeat (3) @(negedge clk);
        done_flag = 1'b1;
    end
endmodule